// File: doc/BRIEF.md
# Local Bus Transfer Timeout Monitor

This block guards each transfer on a local processor bus. When a transfer-start strobe is seen, it begins counting microsecond ticks. The count ends when either a normal acknowledge or an error acknowledge comes back. If the tick count reaches the selected limit first, the block answers the transfer with a one-cycle transfer-error-acknowledge pulse, so the bus master cannot hang on a target that never replies.

Transfers that are marked as headed for the system backplane bus are not timed here, because a separate path covers them. A 2-bit select sets the limit. Three codes give fixed limits and the fourth turns the monitor off. The select is captured when a transfer starts, so changing it affects only later transfers. The tick comes from an external prescaler and is a one-clock enable that arrives once per microsecond.

Top module: `lbTimeoutMon`

## Requirements
- R1: After reset, with `limitSel` at code 0 and no start strobe, `xferErrAck` is low.
- R2: Select code 0 sets the limit to 8 ticks. With `usTick` high every cycle and no acknowledge, `xferErrAck` rises on the 9th rising clock edge after the edge that samples `xferStart` high.
- R3: Select code 1 sets the limit to 64 ticks and code 2 sets it to 256 ticks. With continuous ticks, the pulse comes on edge 65 or edge 257 after the start edge.
- R4: Select code 3 disables the timer. A transfer started under code 3 never produces `xferErrAck`.
- R5: A start strobe with `toBackplane` high starts no timing, and no `xferErrAck` follows it.
- R6: An acknowledge on `normAck` or `errAck` ends the timing and no pulse follows. This also applies when the acknowledge is sampled on the same edge on which expiry is detected, which is the 9th edge for code 0. An acknowledge sampled on that edge wins over the error.
- R7: `xferErrAck` is high for exactly one cycle. After the pulse, no further pulse comes until a new start strobe arrives.
- R8: The limit is captured from `limitSel` on the start edge. Changing `limitSel` while a transfer is being timed does not move the pulse.
- R9: The count advances only on cycles where `usTick` is high. While `usTick` stays low, no pulse comes however many cycles pass.
- R10: A start strobe that arrives while a transfer is being timed restarts the count from zero, using the select value at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferStart | input | 1 | Transfer-start strobe, high for one cycle |
| normAck | input | 1 | Normal transfer acknowledge |
| errAck | input | 1 | Error transfer acknowledge from the target |
| toBackplane | input | 1 | High when the transfer starting in this cycle is headed for the backplane bus |
| limitSel | input | 2 | Timeout select: 0 = 8 ticks, 1 = 64 ticks, 2 = 256 ticks, 3 = off |
| usTick | input | 1 | Microsecond tick enable |
| xferErrAck | output | 1 | One-cycle transfer-error-acknowledge pulse |

## Verification
Two events can fall on the same clock edge: the count reaching its limit, and an acknowledge arriving from the target. The bench provokes this by raising `normAck` or `errAck` so that it is sampled on exactly the 9th edge after a code-0 start, which is the edge where the error would otherwise be issued. It then checks that `xferErrAck` stays low. A second case raises the acknowledge one edge earlier to confirm plain cancellation. Comparing the two cases against the undisturbed pulse position shows that the acknowledge has priority.

// File: rtl/lbto_pkg.sv
package lbto_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the limit and zero the count
    logic count;  // advance the count by one tick
  } ctrlStrobes_t;

  localparam logic [1:0] SEL_OFF = 2'd3;

endpackage

// File: rtl/lbto_datapath.sv
module lbto_datapath
  import lbto_pkg::*;
#(
  parameter int LIM0 = 8,
  parameter int LIM1 = 64,
  parameter int LIM2 = 256,
  localparam int MAXLIM = (LIM0 > LIM1) ? ((LIM0 > LIM2) ? LIM0 : LIM2)
                                        : ((LIM1 > LIM2) ? LIM1 : LIM2),
  localparam int CNT_W = $clog2(MAXLIM + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [1:0]   limitSel,
  output logic         expired
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limQ;
  logic [CNT_W-1:0] limNext;

  always_comb begin
    unique case (limitSel)
      2'd0:    limNext = CNT_W'(LIM0);
      2'd1:    limNext = CNT_W'(LIM1);
      default: limNext = CNT_W'(LIM2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      limQ <= CNT_W'(LIM0);
    end else if (strb.load) begin
      cntQ <= '0;
      limQ <= limNext;
    end else if (strb.count) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign expired = (cntQ == limQ);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= limQ); // R2

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !expired); // R10

endmodule

// File: rtl/lbto_ctrl.sv
module lbto_ctrl
  import lbto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         xferStart,
  input  logic         normAck,
  input  logic         errAck,
  input  logic         toBackplane,
  input  logic [1:0]   limitSel,
  input  logic         usTick,
  input  logic         expired,
  output ctrlStrobes_t strb,
  output logic         xferErrAck
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t stateQ, stateNext;
  logic   errNext;
  logic   anyAck;
  logic   startTimed;

  assign anyAck     = normAck | errAck;
  assign startTimed = xferStart & ~toBackplane & (limitSel != SEL_OFF);

  always_comb begin
    stateNext  = stateQ;
    errNext    = 1'b0;
    strb.load  = 1'b0;
    strb.count = 1'b0;
    if (xferStart) begin
      strb.load = startTimed;
      stateNext = startTimed ? ST_RUN : ST_IDLE;
    end else if (stateQ == ST_RUN) begin
      if (anyAck) begin
        stateNext = ST_IDLE;
      end else if (expired) begin
        stateNext = ST_IDLE;
        errNext   = 1'b1;
      end else begin
        strb.count = usTick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      xferErrAck <= 1'b0;
    end else begin
      stateQ     <= stateNext;
      xferErrAck <= errNext;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferErrAck |=> !xferErrAck); // R7

  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    anyAck |=> !xferErrAck); // R6

  AST_UNTIMED_START: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && (toBackplane || limitSel == SEL_OFF)) |=> (stateQ == ST_IDLE)); // R5

  AST_PULSE_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferErrAck) |-> (stateQ == ST_IDLE && $past(stateQ) == ST_RUN)); // R2

  AST_NO_TICK_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && !expired) |=> !xferErrAck); // R9

endmodule

// File: rtl/lbTimeoutMon.sv
module lbTimeoutMon
  import lbto_pkg::*;
#(
  parameter int LIM0 = 8,
  parameter int LIM1 = 64,
  parameter int LIM2 = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferStart,
  input  logic       normAck,
  input  logic       errAck,
  input  logic       toBackplane,
  input  logic [1:0] limitSel,
  input  logic       usTick,
  output logic       xferErrAck
);

  ctrlStrobes_t strb;
  logic         expired;

  lbto_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .xferStart   (xferStart),
    .normAck     (normAck),
    .errAck      (errAck),
    .toBackplane (toBackplane),
    .limitSel    (limitSel),
    .usTick      (usTick),
    .expired     (expired),
    .strb        (strb),
    .xferErrAck  (xferErrAck)
  );

  lbto_datapath #(
    .LIM0 (LIM0),
    .LIM1 (LIM1),
    .LIM2 (LIM2)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .limitSel (limitSel),
    .expired  (expired)
  );

endmodule

// File: tb/tb_lbTimeoutMon.sv
module tb_lbTimeoutMon;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       xferStart;
  logic       normAck;
  logic       errAck;
  logic       toBackplane;
  logic [1:0] limitSel;
  logic       usTick;
  logic       xferErrAck;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  lbTimeoutMon dut (
    .clk         (clk),
    .rstN        (rstN),
    .xferStart   (xferStart),
    .normAck     (normAck),
    .errAck      (errAck),
    .toBackplane (toBackplane),
    .limitSel    (limitSel),
    .usTick      (usTick),
    .xferErrAck  (xferErrAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a start strobe sampled on the next posedge; return at the following negedge.
  task automatic startXfer(input logic [1:0] sel, input logic bp);
    @(negedge clk);
    limitSel    = sel;
    toBackplane = bp;
    xferStart   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xferStart   = 1'b0;
    toBackplane = 1'b0;
  endtask

  // After startXfer: edge 1 already passed. Return edge index of first pulse, 0 if none.
  task automatic watchErr(input int maxEdges, output int firstEdge, output int pulses);
    firstEdge = 0;
    pulses    = 0;
    for (int k = 1; k <= maxEdges; k++) begin
      if (k > 1) @(negedge clk);
      if (xferErrAck) begin
        pulses++;
        if (firstEdge == 0) firstEdge = k - 1;
      end
      if (k < maxEdges) @(posedge clk);
    end
  endtask

  // Edge index k: observed at negedge after k-th posedge following the start edge.
  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; xferStart = 0; normAck = 0; errAck = 0;
    toBackplane = 0; limitSel = 2'd0; usTick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset output", xferErrAck, 0);
  endtask

  // Count edges after start edge to the pulse (start edge is edge 0).
  task automatic measure(input logic [1:0] sel, input int window, output int edgeAt, output int pulses);
    int f, p;
    startXfer(sel, 1'b0);
    // currently at negedge after start edge (edge 0)
    f = 0; p = 0;
    for (int k = 1; k <= window; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (xferErrAck) begin
        p++;
        if (f == 0) f = k;
      end
    end
    edgeAt = f;
    pulses = p;
  endtask

  task automatic testLimits();
    int e, p;
    measure(2'd0, 40, e, p);
    check("R2 code0 pulse edge", e, 9);
    check("R7 code0 pulse count", p, 1);
    measure(2'd1, 100, e, p);
    check("R3 code1 pulse edge", e, 65);
    check("R7 code1 pulse count", p, 1);
    measure(2'd2, 300, e, p);
    check("R3 code2 pulse edge", e, 257);
  endtask

  task automatic testDisabled();
    int e, p;
    measure(2'd3, 400, e, p);
    check("R4 code3 no pulse", p, 0);
  endtask

  task automatic testBackplane();
    int p;
    startXfer(2'd0, 1'b1);
    p = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (xferErrAck) p++;
    end
    check("R5 backplane no pulse", p, 0);
  endtask

  // Ack sampled on edge ackEdge after start edge.
  task automatic ackAt(input int ackEdge, input bit useErr, input string req);
    int p;
    startXfer(2'd0, 1'b0);
    p = 0;
    for (int k = 1; k <= 30; k++) begin
      if (k == ackEdge) begin
        if (useErr) errAck = 1'b1; else normAck = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      normAck = 1'b0; errAck = 1'b0;
      if (xferErrAck) p++;
    end
    check(req, p, 0);
  endtask

  task automatic testAck();
    ackAt(4, 1'b0, "R6 early normal ack");
    ackAt(8, 1'b1, "R6 error ack one edge before expiry");
    ackAt(9, 1'b0, "R6 normal ack on expiry edge wins");
    ackAt(9, 1'b1, "R6 error ack on expiry edge wins");
  endtask

  task automatic testSelLatch();
    int f, p;
    startXfer(2'd0, 1'b0);
    limitSel = 2'd2;
    f = 0; p = 0;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 3) limitSel = 2'd3;
      if (xferErrAck) begin p++; if (f == 0) f = k; end
    end
    check("R8 select latched edge", f, 9);
    check("R7 no repeat after pulse", p, 1);
    limitSel = 2'd0;
  endtask

  task automatic testTickGate();
    int f, p;
    startXfer(2'd0, 1'b0);
    usTick = 1'b0;
    p = 0;
    for (int k = 1; k <= 50; k++) begin
      @(posedge clk); @(negedge clk);
      if (xferErrAck) p++;
    end
    check("R9 no pulse without ticks", p, 0);
    // Four ticks, then gap, then remaining ticks
    usTick = 1'b1;
    waitEdges(4);
    usTick = 1'b0;
    waitEdges(20);
    check("R9 held during gap", xferErrAck, 0);
    usTick = 1'b1;
    f = 0;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (xferErrAck && f == 0) f = k;
    end
    check("R9 pulse after remaining ticks", f, 5);
  endtask

  task automatic testRestart();
    int f;
    startXfer(2'd0, 1'b0);
    waitEdges(5);
    startXfer(2'd0, 1'b0);
    f = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (xferErrAck && f == 0) f = k;
    end
    check("R10 restart pulse edge", f, 9);
  endtask

  initial begin
    doReset();
    testLimits();
    testDisabled();
    testBackplane();
    testAck();
    testSelLatch();
    testTickGate();
    testRestart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule